// File: doc/BRIEF.md
# Double-Rate Pin Capture with 1:4 Gearbox

This block captures one input pin for the core. It supports three capture modes. In single-rate mode the pin is sampled once per system clock. In double-rate mode the pin is sampled on both edges of a fast edge clock, which gives a rising-edge stream and a falling-edge stream, and both are handed to the system clock. In gearbox mode the system clock runs at half the edge-clock rate, and each system clock delivers four consecutive pin samples side by side.

Both double-rate streams first pass through a programmable delay of whole edge-clock periods. The delay comes from a 4-bit code when dynamic delay is on, and from a build-time parameter when it is off. The streams are then re-registered by synchronization flops. A polarity input selects whether these flops run on the true or the inverted edge clock. A transfer-enable input, sampled on the system clock, decides on which system-clock edges new data moves into the output register. A raw, unregistered copy of the pin is always available.

Top module: `ddr_input_gearbox`

## Requirements
- R1: `pad_raw` equals `pad_in` at all times, with no register or delay in the path.
- R2: With `cap_mode` = 2'b00 (single rate), every `sys_clk` edge that loads writes the pin value sampled at that edge to `cap_q[0]` and writes zero to `cap_q[3:1]`. The delay setting has no effect in this mode.
- R3: With `cap_mode` = 2'b01 (double rate), a load writes `cap_q[0]` = a rising-edge sample and `cap_q[1]` = the falling-edge sample that followed it, and writes zero to `cap_q[3:2]`. Successive loads at full rate reproduce the pin bit sequence in arrival order.
- R4: With `cap_mode[1]` = 1 (gearbox) and `sys_clk` at half the edge rate, a load writes four consecutive pin samples. The oldest goes to `cap_q[0]` and the newest to `cap_q[3]`. Successive loads reproduce the pin bit sequence without gaps.
- R5: `sync_inv` = 0 clocks the synchronization flops on the rising edge-clock edge, and `sync_inv` = 1 clocks them on the falling edge. Under either setting the double-rate and gearbox outputs keep the bit order of R3 and R4.
- R6: With `dly_dyn` = 1, code k (0 to 15) on `dly_code` delays both double-rate streams by k edge-clock periods, which is 2k bit positions.
- R7: With `dly_dyn` = 0, the delay is `FIXED_TAP` edge-clock periods, and `dly_code` is ignored.
- R8: On a `sys_clk` edge where `xfer_en` is low, `cap_q` keeps its value.
- R9: `rst_n` low at a clock edge synchronously clears the capture, delay, synchronization and output registers. `cap_q` reads zero after a `sys_clk` edge with `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| edge_clk | input | 1 | Fast capture clock; pin sampled on both edges |
| sys_clk | input | 1 | Core-side clock; equal to edge rate in double-rate mode, half rate in gearbox mode |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| pad_in | input | 1 | Pin data from the input buffer |
| cap_mode | input | 2 | 00 single rate, 01 double rate, 1x gearbox |
| sync_inv | input | 1 | Synchronization flops on inverted edge clock when 1 |
| dly_dyn | input | 1 | 1 selects `dly_code` as delay, 0 selects `FIXED_TAP` |
| dly_code | input | 4 | Dynamic delay in edge-clock periods |
| xfer_en | input | 1 | Load enable for the system-clock output register |
| pad_raw | output | 1 | Unregistered copy of `pad_in` |
| cap_q | output | 4 | Captured data, oldest sample in bit 0 |

## Verification
The assertions assume that reset is low at the first `sys_clk` edge. They also assume that every `sys_clk` edge falls between edge-clock edges, so that transfers never sample a synchronization flop while it changes. The bench meets both conditions by holding `rst_n` low from time zero. It derives `sys_clk` from the edge clock with a quarter-period offset, and it switches the divide ratio only with the mode, before a reset. Pin changes are placed a quarter period away from each edge-clock edge. `xfer_en`, mode and delay settings change only well clear of both clocks' edges, so each captured bit and each load decision is unambiguous.

// File: rtl/ddrcap_pkg.sv
`timescale 1ns/1ps
// Shared types for the double-rate pin capture block.
// Assumes a fixed 1:4 gearbox ratio (two edge-clock pairs per system clock).
package ddrcap_pkg;

    localparam int GEAR_W = 4;

    typedef enum logic [1:0] {
        CAP_SDR  = 2'b00,
        CAP_DDR  = 2'b01,
        CAP_GEAR = 2'b10,
        CAP_GEX  = 2'b11
    } cap_mode_e;

    // One rising-edge sample followed by its falling-edge partner.
    typedef struct packed {
        logic fall;
        logic rise;
    } bit_pair_t;

endpackage

// File: rtl/ddrcap_tap_line.sv
`timescale 1ns/1ps
// Programmable delay of whole clock periods for one captured stream.
// A shift chain of DEPTH flops on the chosen clock edge; sel = 0 passes
// din straight through, sel = k taps the k-th flop.
// Assumes sel is static relative to the data it delays.
module ddrcap_tap_line #(
    parameter int SEL_W     = 4,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    localparam int DEPTH = (1 << SEL_W) - 1;

    logic [DEPTH:1] stg;

    generate
        if (FALL_EDGE) begin : g_fall
            // Shift the chain on the falling edge.
            always_ff @(negedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[DEPTH-1:1], din};
            end
        end else begin : g_rise
            // Shift the chain on the rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[DEPTH-1:1], din};
            end
        end
    endgenerate

    // Pick the tap.
    always_comb begin
        if (sel == '0) dout = din;
        else           dout = stg[sel];
    end
endmodule

// File: rtl/ddrcap_sync.sv
`timescale 1ns/1ps
// Synchronization stage for the two double-rate streams.
// Two flop sets exist: one on the rising and one on the falling edge clock;
// inv selects which set feeds the core side. Each set also keeps the previous
// pair so that a half-rate reader sees four consecutive bits.
// Assumes rise_in changes on rising edges and fall_in on falling edges.
module ddrcap_sync
    import ddrcap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      inv,
    input  logic      rise_in,
    input  logic      fall_in,
    output bit_pair_t pair_new,
    output bit_pair_t pair_old
);
    bit_pair_t p_new, p_old, n_new, n_old;

    // True-edge set: pairs a rise sample with the fall sample after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_new <= '0;
            p_old <= '0;
        end else begin
            p_new <= '{fall: fall_in, rise: rise_in};
            p_old <= p_new;
        end
    end

    // Inverted-edge set: rise bit taken from the true-edge set to keep order.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            n_new <= '0;
            n_old <= '0;
        end else begin
            n_new <= '{fall: fall_in, rise: p_new.rise};
            n_old <= n_new;
        end
    end

    // Polarity select.
    always_comb begin
        pair_new = inv ? n_new : p_new;
        pair_old = inv ? n_old : p_old;
    end
endmodule

// File: rtl/ddrcap_xfer.sv
`timescale 1ns/1ps
// System-clock output register with per-mode packing.
// Loads only on edges where en is high; oldest bit lands in bit 0.
// Assumes sys_clk edges fall between edge-clock edges.
module ddrcap_xfer
    import ddrcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              pad,
    input  bit_pair_t         pair_new,
    input  bit_pair_t         pair_old,
    output logic [GEAR_W-1:0] q
);
    cap_mode_e mode_e;
    assign mode_e = cap_mode_e'(mode);

    // Transfer into the core domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            case (mode_e)
                CAP_SDR: q <= {{(GEAR_W-1){1'b0}}, pad};
                CAP_DDR: q <= {{(GEAR_W-2){1'b0}}, pair_new.fall, pair_new.rise};
                default: q <= {pair_new.fall, pair_new.rise, pair_old.fall, pair_old.rise};
            endcase
        end
    end
endmodule

// File: rtl/ddr_input_gearbox.sv
`timescale 1ns/1ps
// Top of the double-rate pin capture block.
// Samples the pin on both edge-clock edges, delays each stream by a
// programmable number of periods, synchronizes with selectable polarity and
// transfers to the system clock in single-rate, double-rate or 1:4 form.
// Assumes sys_clk is edge-locked to edge_clk (equal or half rate).
module ddr_input_gearbox
    import ddrcap_pkg::*;
#(
    parameter int TAP_W     = 4,
    parameter int FIXED_TAP = 2
) (
    input  logic              edge_clk,
    input  logic              sys_clk,
    input  logic              rst_n,
    input  logic              pad_in,
    input  logic [1:0]        cap_mode,
    input  logic              sync_inv,
    input  logic              dly_dyn,
    input  logic [TAP_W-1:0]  dly_code,
    input  logic              xfer_en,
    output logic              pad_raw,
    output logic [GEAR_W-1:0] cap_q
);
    localparam logic [TAP_W-1:0] FIX_SEL = TAP_W'(FIXED_TAP);

    logic             rise_cap, fall_cap, rise_dly, fall_dly;
    logic [TAP_W-1:0] tap_sel;
    bit_pair_t        pair_new, pair_old;

    // Raw bypass of every register.
    assign pad_raw = pad_in;

    // Delay source select.
    assign tap_sel = dly_dyn ? dly_code : FIX_SEL;

    // Rising-edge capture flop.
    always_ff @(posedge edge_clk) begin
        if (!rst_n) rise_cap <= 1'b0;
        else        rise_cap <= pad_in;
    end

    // Falling-edge capture flop.
    always_ff @(negedge edge_clk) begin
        if (!rst_n) fall_cap <= 1'b0;
        else        fall_cap <= pad_in;
    end

    ddrcap_tap_line #(.SEL_W(TAP_W), .FALL_EDGE(1'b0)) u_rise_dly (
        .clk(edge_clk), .rst_n(rst_n), .din(rise_cap), .sel(tap_sel), .dout(rise_dly)
    );

    ddrcap_tap_line #(.SEL_W(TAP_W), .FALL_EDGE(1'b1)) u_fall_dly (
        .clk(edge_clk), .rst_n(rst_n), .din(fall_cap), .sel(tap_sel), .dout(fall_dly)
    );

    ddrcap_sync u_sync (
        .clk(edge_clk), .rst_n(rst_n), .inv(sync_inv),
        .rise_in(rise_dly), .fall_in(fall_dly),
        .pair_new(pair_new), .pair_old(pair_old)
    );

    ddrcap_xfer u_xfer (
        .clk(sys_clk), .rst_n(rst_n), .en(xfer_en), .mode(cap_mode),
        .pad(pad_in), .pair_new(pair_new), .pair_old(pair_old), .q(cap_q)
    );
endmodule

// File: rtl/ddr_input_gearbox_chk.sv
`timescale 1ns/1ps
// Property checker for the capture block, attached by bind.
// Assumes reset is low at the first sys_clk edge.
module ddr_input_gearbox_chk (
    input logic       sys_clk,
    input logic       rst_n,
    input logic       xfer_en,
    input logic [1:0] cap_mode,
    input logic [3:0] cap_q
);
    assert_sdr_upper_zero_R2: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (cap_mode == 2'b00 && xfer_en) |=> (cap_q[3:1] == 3'b000));

    assert_ddr_upper_zero_R3: assert property (@(posedge sys_clk) disable iff (!rst_n)
        (cap_mode == 2'b01 && xfer_en) |=> (cap_q[3:2] == 2'b00));

    assert_hold_when_idle_R8: assert property (@(posedge sys_clk) disable iff (!rst_n)
        !xfer_en |=> $stable(cap_q));

    assert_reset_clears_R9: assert property (@(posedge sys_clk)
        !rst_n |=> (cap_q == 4'b0000));
endmodule

bind ddr_input_gearbox ddr_input_gearbox_chk u_chk (
    .sys_clk(sys_clk), .rst_n(rst_n), .xfer_en(xfer_en),
    .cap_mode(cap_mode), .cap_q(cap_q)
);

// File: tb/sim_ddr_input_gearbox.sv
`timescale 1ns/1ps
module sim_ddr_input_gearbox;
    localparam int FIX   = 3;
    localparam int LEAD  = 8;
    localparam int PLEN  = 40;
    localparam int NB    = 200;
    localparam int RECN  = 160;

    logic       edge_clk = 1'b0;
    logic       sys_clk  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       pad_in   = 1'b0;
    logic [1:0] cap_mode = 2'b01;
    logic       sync_inv = 1'b0;
    logic       dly_dyn  = 1'b1;
    logic [3:0] dly_code = 4'd0;
    logic       xfer_en  = 1'b1;
    logic       pad_raw;
    logic [3:0] cap_q;

    int total = 0;
    int bad   = 0;
    int ref_off = 0;
    int off;
    logic [PLEN-1:0] pat;
    logic rec [RECN];

    ddr_input_gearbox #(.TAP_W(4), .FIXED_TAP(FIX)) u0 (
        .edge_clk(edge_clk), .sys_clk(sys_clk), .rst_n(rst_n), .pad_in(pad_in),
        .cap_mode(cap_mode), .sync_inv(sync_inv), .dly_dyn(dly_dyn),
        .dly_code(dly_code), .xfer_en(xfer_en), .pad_raw(pad_raw), .cap_q(cap_q)
    );

    // 200 MHz edge clock
    always #2.5 edge_clk = ~edge_clk;

    // System clock: quarter period after each edge-clock rise, half rate in gearbox mode
    always begin
        @(posedge edge_clk);
        #1.25;
        if (!cap_mode[1]) begin
            sys_clk = 1'b1;
            #2.5;
            sys_clk = 1'b0;
        end else begin
            sys_clk = ~sys_clk;
        end
    end

    typedef struct packed {
        logic [1:0] m;
        logic       p;
        logic       d;
        logic [3:0] c;
        logic       is_ref;
        logic [5:0] shift;
        logic [3:0] tf;
        logic [3:0] ts;
    } row_t;

    localparam int NROWS = 11;
    localparam row_t ROWS [NROWS] = '{
        '{2'b01, 1'b0, 1'b1, 4'd0,  1'b1, 6'd0,  4'd3, 4'd6}, // R3 reference
        '{2'b01, 1'b0, 1'b1, 4'd5,  1'b0, 6'd10, 4'd3, 4'd6}, // R6 code 5
        '{2'b01, 1'b0, 1'b0, 4'd9,  1'b0, 6'd6,  4'd3, 4'd7}, // R7 code ignored
        '{2'b01, 1'b1, 1'b1, 4'd0,  1'b1, 6'd0,  4'd5, 4'd6}, // R5 reference
        '{2'b01, 1'b1, 1'b1, 4'd15, 1'b0, 6'd30, 4'd5, 4'd6}, // R6 max code
        '{2'b10, 1'b0, 1'b1, 4'd0,  1'b1, 6'd0,  4'd4, 4'd6}, // R4 reference
        '{2'b10, 1'b0, 1'b1, 4'd4,  1'b0, 6'd8,  4'd4, 4'd6}, // R6 gearbox
        '{2'b10, 1'b1, 1'b1, 4'd0,  1'b1, 6'd0,  4'd5, 4'd6}, // R5 gearbox
        '{2'b10, 1'b1, 1'b0, 4'd1,  1'b0, 6'd6,  4'd5, 4'd7}, // R7 gearbox
        '{2'b00, 1'b0, 1'b1, 4'd0,  1'b1, 6'd0,  4'd2, 4'd2}, // R2 reference
        '{2'b00, 1'b0, 1'b1, 4'd7,  1'b0, 6'd0,  4'd2, 4'd2}  // R2 delay unused
    };

    function automatic string tag(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string t, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
        end
    endtask

    function automatic logic stim_bit(input int i);
        if (i >= LEAD && i < LEAD + PLEN) return pat[i - LEAD];
        return 1'b0;
    endfunction

    task automatic run_stream(input logic [1:0] m, input logic p, input logic d,
                              input logic [3:0] c, output int found);
        int bps;
        bps = (m == 2'b00) ? 1 : (m == 2'b01) ? 2 : 4;
        cap_mode = m; sync_inv = p; dly_dyn = d; dly_code = c;
        xfer_en = 1'b1; pad_in = 1'b0; rst_n = 1'b0;
        repeat (4) @(posedge sys_clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge sys_clk);
        fork
            begin
                if (m == 2'b00) begin
                    #2.5;
                    for (int i = 0; i < NB; i++) begin pad_in = stim_bit(i); #5; end
                end else begin
                    for (int i = 0; i < NB; i++) begin pad_in = stim_bit(i); #2.5; end
                end
            end
            begin
                for (int n = 0; n < RECN / bps; n++) begin
                    @(posedge sys_clk);
                    #2;
                    for (int j = 0; j < bps; j++) rec[n * bps + j] = cap_q[j];
                end
            end
        join
        found = -1;
        for (int o = 0; o <= RECN - PLEN; o++) begin
            bit ok;
            ok = 1'b1;
            for (int k = 0; k < PLEN; k++) if (rec[o + k] !== pat[k]) ok = 1'b0;
            if (ok && found < 0) found = o;
        end
    endtask

    // Watchdog
    initial begin
        #500us;
        total++;
        bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] lf;
        lf = 8'hA5;
        for (int i = 0; i < PLEN; i++) begin
            pat[i] = lf[0];
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
        pat[0] = 1'b1;

        // R9: reset state with pin high
        pad_in = 1'b1;
        repeat (4) @(posedge sys_clk);
        #2 chk("R9", cap_q, 0);
        rst_n = 1'b1;
        repeat (30) @(posedge sys_clk);
        #2 chk("R3", cap_q, 3);
        rst_n = 1'b0;
        repeat (2) @(posedge sys_clk);
        #2 chk("R9", cap_q, 0);
        rst_n = 1'b1;

        // R2: single-rate packing
        cap_mode = 2'b00;
        repeat (10) @(posedge sys_clk);
        #2 chk("R2", cap_q, 1);

        // R4: gearbox packing with constant high
        cap_mode = 2'b10;
        repeat (30) @(posedge sys_clk);
        #2 chk("R4", cap_q, 15);

        // R8: hold while transfer enable is low
        xfer_en = 1'b0;
        pad_in = 1'b0;
        repeat (20) @(posedge sys_clk);
        #2 chk("R8", cap_q, 15);
        xfer_en = 1'b1;
        repeat (20) @(posedge sys_clk);
        #2 chk("R8", cap_q, 0);

        // R1: raw bypass follows pin
        pad_in = 1'b1;
        #0.5 chk("R1", pad_raw, 1);
        pad_in = 1'b0;
        #0.5 chk("R1", pad_raw, 0);

        // Table of streamed patterns
        for (int r = 0; r < NROWS; r++) begin
            run_stream(ROWS[r].m, ROWS[r].p, ROWS[r].d, ROWS[r].c, off);
            chk(tag(ROWS[r].tf), (off >= 0) ? 1 : 0, 1);
            if (ROWS[r].is_ref) ref_off = off;
            else chk(tag(ROWS[r].ts), off - ref_off, int'(ROWS[r].shift));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule